// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Block

This block is one logic tile of an SRAM-configured array. Four lookup inputs (`in_abcd`, bit 0 = A up to bit 3 = D) and a fifth input E feed a function generator built from two 16-entry lookup tables. Depending on its mode, the generator acts as one arbitrary 5-input function, as two separate 4-input functions F and G, or as a restricted 6-variable function in which E chooses between two 4-input tables. Two flip-flops share a clock, clock enable and reset. Each captures F, G or the direct input `din`, and both feed back into the generator. Each of the outputs X and Y shows either a function result or a flip-flop.

All personality bits sit in one 44-bit serial chain with its own shift clock. A load-done flag rises when the last bit arrives. Until then both outputs read 0 and the flip-flops stay cleared. The chain ignores shifting after the flag is set, and a global reset clears the chain, the flag and both flip-flops.

Chain bit positions: [15:0] table F, [31:16] table G, [33:32] mode, [35:34] F extra-input select, [37:36] G extra-input select, [39:38] Q1 data select, [41:40] Q2 data select, [42] X registered, [43] Y registered.

Top module: `clb_dual_lut`

## Requirements
- R1: Each rising `cfg_clk` with `cfg_shift` high moves the chain one place toward bit 0, and `cfg_sdi` enters at bit 43, so the first bit shifted ends in bit 0. `cfg_done` is still 0 after 43 such shifts and is 1 after the 44th.
- R2: While `cfg_done` is 0, `x_out` and `y_out` are 0 and both flip-flops stay 0 whatever `ce` does.
- R3: Once `cfg_done` is 1, further shift pulses change neither the configuration nor the flag.
- R4: Mode codes 0 and 3 (single 5-input function): F = G = table G[{D,C,B,A}] when E=1, else table F[{D,C,B,A}].
- R5: Mode code 1 (split): F = table F[{xf,C,B,A}] and G = table G[{xg,D,C,B}]. The extra inputs xf and xg are picked by their 2-bit selects: 0 = E, 1 = Q1, 2 = Q2, 3 = constant 0.
- R6: Mode code 2 (wide): F = G = table G[{xg,C,B,A}] when E=1, else table F[{D,C,B,A}], with xg selected as in R5.
- R7: At a rising `clk` with `ce` high and `cfg_done` set, each flip-flop loads its selected source: code 0 = F, 1 = G, 2 or 3 = `din`.
- R8: At a rising `clk` with `ce` low, both flip-flops keep their values.
- R9: Driving `rst_n` low clears both flip-flops, the chain and `cfg_done` at once, with no clock, and so forces both outputs to 0.
- R10: After loading, `x_out` is Q1 when bit 42 is 1, else F. `y_out` is Q2 when bit 43 is 1, else G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock for the flip-flops |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_shift | input | 1 | Shift enable for the chain |
| cfg_sdi | input | 1 | Serial configuration data |
| in_abcd | input | 4 | Lookup inputs A (bit 0) to D (bit 3) |
| in_e | input | 1 | Fifth logic input E |
| din | input | 1 | Direct flip-flop data input |
| ce | input | 1 | Flip-flop clock enable |
| x_out | output | 1 | Output X |
| y_out | output | 1 | Output Y |
| cfg_done | output | 1 | Configuration load complete |

## Verification
The single-function and split modes are each swept over all 32 combinations of A to E. In split mode, E steering only F while G ignores it separates the two index maps, and asymmetric tables expose any swapped or shifted address bit. Wide mode and feedback runs use a pseudo-random input sequence with toggling `din` and `ce`, so the Q1/Q2 extra-input selects, the data selects and enable hold are checked against a cycle model of the flip-flops. Dedicated sequences cover a partly loaded chain, shifting after load and a reset mid-run that follows a flip-flop set to 1.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;
  localparam int CLB_K     = 4;
  localparam int CLB_LUT_W = 1 << CLB_K;

  typedef enum logic [1:0] {FG_FIVE = 2'd0, FG_SPLIT = 2'd1, FG_WIDE = 2'd2, FG_FIVE_ALT = 2'd3} fg_mode_e;
  typedef enum logic [1:0] {XS_E = 2'd0, XS_Q1 = 2'd1, XS_Q2 = 2'd2, XS_ZERO = 2'd3} xsel_e;
  typedef enum logic [1:0] {DS_F = 2'd0, DS_G = 2'd1, DS_DIN = 2'd2, DS_DIN_ALT = 2'd3} dsel_e;

  typedef struct packed {
    logic                 y_reg;
    logic                 x_reg;
    dsel_e                d2;
    dsel_e                d1;
    xsel_e                xg;
    xsel_e                xf;
    fg_mode_e             mode;
    logic [CLB_LUT_W-1:0] lut_g;
    logic [CLB_LUT_W-1:0] lut_f;
  } clb_cfg_t;

  localparam int CLB_CFG_W = $bits(clb_cfg_t);
endpackage

// File: rtl/clb_rst_sync.sv
`timescale 1ns/1ps
module clb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_r <= '0;
    else           sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_r[STAGES-1];
endmodule

// File: rtl/clb_cfg_chain.sv
`timescale 1ns/1ps
module clb_cfg_chain #(
  parameter int W = clb_pkg::CLB_CFG_W
) (
  input  logic         cfg_clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_in,
  output logic [W-1:0] word,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt, cnt_nx;
  logic [W-1:0]  word_nx;
  logic          done_nx;
  logic          take;

  assign take = shift_en & ~done;

  always_comb begin
    word_nx = word;
    cnt_nx  = cnt;
    done_nx = done;
    if (take) begin
      word_nx = {shift_in, word[W-1:1]};
      cnt_nx  = cnt + 1'b1;
      if (cnt == CW'(W - 1)) done_nx = 1'b1;
    end
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      word <= word_nx;
      cnt  <= cnt_nx;
      done <= done_nx;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done |=> done); // R3
  AST_CFG_FROZEN: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done |=> $stable(word)); // R3
  AST_DONE_AT_COUNT: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(done) |-> (cnt == CW'(W))); // R1
endmodule

// File: rtl/clb_lut.sv
`timescale 1ns/1ps
module clb_lut #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] tbl,
  input  logic [K-1:0]      idx,
  output logic              bit_out
);
  assign bit_out = tbl[idx];
endmodule

// File: rtl/clb_funcgen.sv
`timescale 1ns/1ps
module clb_funcgen
  import clb_pkg::*;
(
  input  clb_cfg_t         cfg,
  input  logic [CLB_K-1:0] abcd,
  input  logic             e,
  input  logic             q1,
  input  logic             q2,
  output logic             f,
  output logic             g
);
  logic [CLB_K-1:0]     idx [2];
  logic [CLB_LUT_W-1:0] tbl [2];
  logic                 lut_o [2];
  logic                 xf_v, xg_v;

  function automatic logic pick_extra(xsel_e s, logic ev, logic a, logic b);
    case (s)
      XS_E:    return ev;
      XS_Q1:   return a;
      XS_Q2:   return b;
      default: return 1'b0;
    endcase
  endfunction

  assign xf_v   = pick_extra(cfg.xf, e, q1, q2);
  assign xg_v   = pick_extra(cfg.xg, e, q1, q2);
  assign tbl[0] = cfg.lut_f;
  assign tbl[1] = cfg.lut_g;

  always_comb begin
    idx[0] = (cfg.mode == FG_SPLIT) ? {xf_v, abcd[CLB_K-2:0]} : abcd;
    case (cfg.mode)
      FG_SPLIT: idx[1] = {xg_v, abcd[CLB_K-1:1]};
      FG_WIDE:  idx[1] = {xg_v, abcd[CLB_K-2:0]};
      default:  idx[1] = abcd;
    endcase
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_lut
    clb_lut #(.K(CLB_K)) u_lut (
      .tbl    (tbl[gi]),
      .idx    (idx[gi]),
      .bit_out(lut_o[gi])
    );
  end

  always_comb begin
    if (cfg.mode == FG_SPLIT) begin
      f = lut_o[0];
      g = lut_o[1];
    end else begin
      f = e ? lut_o[1] : lut_o[0];
      g = f;
    end
  end
endmodule

// File: rtl/clb_regs.sv
`timescale 1ns/1ps
module clb_regs
  import clb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce,
  input  logic  run,
  input  dsel_e sel1,
  input  dsel_e sel2,
  input  logic  f,
  input  logic  g,
  input  logic  din,
  output logic  q1,
  output logic  q2
);
  logic [1:0] q_r, q_nx, d_v;
  dsel_e      sel [2];

  assign sel[0] = sel1;
  assign sel[1] = sel2;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      case (sel[i])
        DS_F:    d_v[i] = f;
        DS_G:    d_v[i] = g;
        default: d_v[i] = din;
      endcase
    end
    q_nx = (ce && run) ? d_v : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q1 = q_r[0];
  assign q2 = q_r[1];

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && run) |=> $stable(q_r)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (q_r == 2'b00)); // R2
  AST_DIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && run && (sel1 == DS_DIN || sel1 == DS_DIN_ALT)) |=> (q_r[0] == $past(din))); // R7
endmodule

// File: rtl/clb_dual_lut.sv
`timescale 1ns/1ps
module clb_dual_lut
  import clb_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clk,
  input  logic             cfg_shift,
  input  logic             cfg_sdi,
  input  logic [CLB_K-1:0] in_abcd,
  input  logic             in_e,
  input  logic             din,
  input  logic             ce,
  output logic             x_out,
  output logic             y_out,
  output logic             cfg_done
);
  logic                 rst_n_clk, rst_n_cfg;
  logic [CLB_CFG_W-1:0] cfg_word;
  clb_cfg_t             cfg;
  logic                 f, g, q1, q2;

  clb_rst_sync #(.STAGES(RST_STAGES)) u_rs_clk (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_clk));
  clb_rst_sync #(.STAGES(RST_STAGES)) u_rs_cfg (
    .clk(cfg_clk), .rst_n_in(rst_n), .rst_n_out(rst_n_cfg));

  clb_cfg_chain #(.W(CLB_CFG_W)) u_chain (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n_cfg),
    .shift_en(cfg_shift),
    .shift_in(cfg_sdi),
    .word    (cfg_word),
    .done    (cfg_done)
  );

  assign cfg = cfg_word;

  clb_funcgen u_fg (
    .cfg (cfg),
    .abcd(in_abcd),
    .e   (in_e),
    .q1  (q1),
    .q2  (q2),
    .f   (f),
    .g   (g)
  );

  clb_regs u_regs (
    .clk  (clk),
    .rst_n(rst_n_clk),
    .ce   (ce),
    .run  (cfg_done),
    .sel1 (cfg.d1),
    .sel2 (cfg.d2),
    .f    (f),
    .g    (g),
    .din  (din),
    .q1   (q1),
    .q2   (q2)
  );

  assign x_out = cfg_done & (cfg.x_reg ? q1 : f);
  assign y_out = cfg_done & (cfg.y_reg ? q2 : g);
endmodule

// File: tb/clb_dual_lut_tb.sv
`timescale 1ns/1ps
module clb_dual_lut_tb;
  import clb_pkg::*;

  logic       clk = 1'b0, rst_n = 1'b0, cfg_clk = 1'b0, cfg_shift = 1'b0, cfg_sdi = 1'b0;
  logic [3:0] in_abcd = '0;
  logic       in_e = 1'b0, din = 1'b0, ce = 1'b0;
  logic       x_out, y_out, cfg_done;

  always #2.5 clk = ~clk;

  clb_dual_lut u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
    .in_abcd(in_abcd), .in_e(in_e), .din(din), .ce(ce),
    .x_out(x_out), .y_out(y_out), .cfg_done(cfg_done)
  );

  int n_cmp = 0, n_bad = 0;
  typedef struct { logic x; logic y; string tag; } exp_t;
  exp_t sbq[$];

  clb_cfg_t mc;
  logic     mdone = 1'b0, mq1 = 1'b0, mq2 = 1'b0;
  logic [7:0] lf = 8'hA5;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic pick_x(xsel_e s, logic e, logic a, logic b);
    case (s)
      XS_E: return e; XS_Q1: return a; XS_Q2: return b; default: return 1'b0;
    endcase
  endfunction

  function automatic logic pick_d(dsel_e s, logic f, logic g, logic d);
    case (s)
      DS_F: return f; DS_G: return g; default: return d;
    endcase
  endfunction

  task automatic model_fg(input logic [3:0] a, input logic e, output logic f, output logic g);
    logic xf, xg, lo, hi;
    xf = pick_x(mc.xf, e, mq1, mq2);
    xg = pick_x(mc.xg, e, mq1, mq2);
    case (mc.mode)
      FG_SPLIT: begin f = mc.lut_f[{xf, a[2:0]}]; g = mc.lut_g[{xg, a[3:1]}]; end
      FG_WIDE: begin
        lo = mc.lut_f[a]; hi = mc.lut_g[{xg, a[2:0]}];
        f = e ? hi : lo; g = f;
      end
      default: begin f = e ? mc.lut_g[a] : mc.lut_f[a]; g = f; end
    endcase
  endtask

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      exp_t it;
      it = sbq.pop_front();
      check(it.tag, {x_out, y_out}, {it.x, it.y});
    end
  end

  // driver: called just after a rising edge
  task automatic step(input logic [3:0] a, input logic e, input logic dn, input logic c, input string tag);
    logic f, g;
    exp_t it;
    in_abcd = a; in_e = e; din = dn; ce = c;
    f = 1'b0; g = 1'b0;
    if (mdone) begin
      model_fg(a, e, f, g);
      it.x = mc.x_reg ? mq1 : f;
      it.y = mc.y_reg ? mq2 : g;
    end else begin
      it.x = 1'b0; it.y = 1'b0;
    end
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    if (mdone && c) begin
      mq1 = pick_d(mc.d1, f, g, dn);
      mq2 = pick_d(mc.d2, f, g, dn);
    end
    #1;
  endtask

  task automatic do_reset();
    ce = 1'b0; cfg_shift = 1'b0;
    rst_n = 1'b0; mdone = 1'b0; mq1 = 1'b0; mq2 = 1'b0;
    #7;
    rst_n = 1'b1;
    repeat (3) begin #2 cfg_clk = 1'b1; #2 cfg_clk = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic shift_bits(input clb_cfg_t c, input int from, input int upto);
    logic [CLB_CFG_W-1:0] w;
    w = c;
    ce = 1'b0;
    for (int i = from; i < upto; i++) begin
      cfg_sdi = w[i]; cfg_shift = 1'b1;
      #2 cfg_clk = 1'b1;
      #2 cfg_clk = 1'b0;
    end
    cfg_shift = 1'b0;
    if (upto == CLB_CFG_W && !mdone) begin mc = c; mdone = 1'b1; end
    @(posedge clk);
    #1;
  endtask

  task automatic next_rand();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  endtask

  initial begin
    #200us;
    n_cmp++; n_bad++;
    $display("FAIL watchdog all-reqs actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clb_cfg_t ca, cb, cc, cd, ce_cfg, junk;

    do_reset();
    check("R9 reset state outputs", {x_out, y_out}, 2'b00);
    check("R9 reset state done", {1'b0, cfg_done}, 2'b00);

    // R4 single 5-input function
    ca = '0; ca.mode = FG_FIVE; ca.lut_f = 16'h6996; ca.lut_g = 16'h8001;
    ca.d1 = DS_DIN; ca.d2 = DS_F;
    shift_bits(ca, 0, CLB_CFG_W - 1);
    check("R1 done low after 43 bits", {1'b0, cfg_done}, 2'b00);
    for (int i = 0; i < 4; i++) step(4'hF, 1'b1, 1'b1, 1'b1, "R2 outputs gated before done");
    shift_bits(ca, CLB_CFG_W - 1, CLB_CFG_W);
    check("R1 done high after 44 bits", {1'b0, cfg_done}, 2'b01);
    for (int i = 0; i < 32; i++) step(i[3:0], i[4], 1'b0, 1'b0, "R4 five-input sweep");

    // R3 shifting after done
    junk = '1;
    shift_bits(junk, 0, 20);
    check("R3 done stays set", {1'b0, cfg_done}, 2'b01);
    for (int i = 0; i < 32; i += 3) step(i[3:0], i[4], 1'b0, 1'b0, "R3 config unchanged");

    // R5 split with E and constant-0 extras
    do_reset();
    cb = '0; cb.mode = FG_SPLIT; cb.lut_f = 16'hA5C3; cb.lut_g = 16'h1E78;
    cb.xf = XS_E; cb.xg = XS_ZERO;
    shift_bits(cb, 0, CLB_CFG_W);
    for (int i = 0; i < 32; i++) step(i[3:0], i[4], 1'b0, 1'b0, "R5 split sweep");

    // R5/R7 split with Q feedback, flops from din
    do_reset();
    cc = '0; cc.mode = FG_SPLIT; cc.lut_f = 16'hF0F0 ^ 16'h0C35; cc.lut_g = 16'h3C96;
    cc.xf = XS_Q1; cc.xg = XS_Q2; cc.d1 = DS_DIN; cc.d2 = DS_DIN_ALT;
    shift_bits(cc, 0, CLB_CFG_W);
    for (int i = 0; i < 40; i++) begin
      next_rand();
      step(lf[3:0], lf[4], lf[6], 1'b1, "R7 din capture with R5 feedback");
    end

    // R6/R7/R8/R10 wide mode, registered outputs, toggling enable
    do_reset();
    cd = '0; cd.mode = FG_WIDE; cd.lut_f = 16'h4B2D; cd.lut_g = 16'hE817;
    cd.xg = XS_Q1; cd.d1 = DS_DIN; cd.d2 = DS_F; cd.x_reg = 1'b1; cd.y_reg = 1'b1;
    shift_bits(cd, 0, CLB_CFG_W);
    for (int i = 0; i < 48; i++) begin
      next_rand();
      step(lf[3:0], lf[4], lf[5], lf[7] | lf[2], "R8 hold and R10 registered outputs");
    end
    cd.x_reg = 1'b0; cd.y_reg = 1'b0;
    do_reset();
    shift_bits(cd, 0, CLB_CFG_W);
    for (int i = 0; i < 40; i++) begin
      next_rand();
      step(lf[3:0], lf[4], lf[1], lf[6], "R6 wide function with Q1 extra");
    end

    // R9 async reset mid-run, mode 3, Q1 from F, Q2 from G
    do_reset();
    ce_cfg = '0; ce_cfg.mode = FG_FIVE_ALT; ce_cfg.lut_f = 16'hFFFF; ce_cfg.lut_g = 16'hFFFF;
    ce_cfg.d1 = DS_F; ce_cfg.d2 = DS_G; ce_cfg.x_reg = 1'b1; ce_cfg.y_reg = 1'b0;
    shift_bits(ce_cfg, 0, CLB_CFG_W);
    step(4'h3, 1'b0, 1'b0, 1'b1, "R7 F capture");
    step(4'h3, 1'b0, 1'b0, 1'b0, "R10 X shows Q1");
    rst_n = 1'b0;
    #1;
    check("R9 async clear outputs", {x_out, y_out}, 2'b00);
    check("R9 async clear done", {1'b0, cfg_done}, 2'b00);
    do_reset();
    shift_bits(ce_cfg, 0, CLB_CFG_W);
    step(4'h3, 1'b0, 1'b0, 1'b0, "R9 Q1 cleared after reset");

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule